// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level I2C receiver of a slave port. It is handed a byte strobe with the received byte, plus one-cycle pulses for START (or repeated START) and STOP. It decides whether to acknowledge each byte. Only the first byte after a START is an address byte. It is compared against the device's 7-bit address and against the general call byte (all zeros).

The device address is built from two sources. The upper five bits come from a programmable register. The lower two bits come from strap pins, which are captured while reset is held. A general call is acknowledged and then handled exactly like a transfer to the device's own address: there is no separate indication, and the bytes that follow are passed on as ordinary data. The matcher only acts while the I2C slave mode enable is high.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held and just after it, `ack_o`, `addressed_o`, `data_stb_o` and `rw_o` are 0.
- R2: An address byte whose bits [7:1] equal {register value, captured straps} gives `ack_o`=1 one cycle after the byte strobe, and `addressed_o`=1 from then on.
- R3: The address byte 8'h00 is acknowledged as a general call and sets `addressed_o`, with `rw_o`=0. No output distinguishes it from an own-address match.
- R4: On a matching address byte, bit 0 of that byte is latched onto `rw_o` (1 = read, 0 = write).
- R5: A non-matching address byte is not acknowledged. Every later byte is also not acknowledged until the next START.
- R6: While addressed, each byte is acknowledged and presented on `data_o` with a one-cycle `data_stb_o` pulse, and this is the same after a general call.
- R7: Only the first byte after START is compared. A later byte equal to the address byte is passed on as data.
- R8: A STOP pulse clears `addressed_o` in the next cycle. Bytes after it are not acknowledged until a START and a matching address byte.
- R9: A repeated START while addressed makes the next byte an address byte again, and `rw_o` takes its new bit 0.
- R10: With the slave mode enable low, no byte is acknowledged and `addressed_o` falls to 0 in the next cycle.
- R11: A register write takes effect for address bytes strobed in later cycles. An address byte strobed in the same cycle as the write is compared with the old value.
- R12: Strap inputs are sampled only while reset is held. Changing them afterwards does not alter the address.
- R13: A STOP pulse in the same cycle as a byte strobe wins: the byte is not acknowledged and `addressed_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| slave_mode_i | input | 1 | High when the port operates as an I2C slave |
| addr_wr_i | input | 1 | Write strobe for the address register |
| addr_wdata_i | input | 5 | New upper address bits [6:2] |
| strap_i | input | 2 | Strap pins giving address bits [1:0] |
| start_i | input | 1 | START or repeated START pulse |
| stop_i | input | 1 | STOP pulse |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, address in [7:1], direction in [0] |
| ack_o | output | 1 | Acknowledge decision for the byte strobed in the previous cycle |
| addressed_o | output | 1 | Device is selected for the current transfer |
| rw_o | output | 1 | Latched transfer direction |
| data_stb_o | output | 1 | A data byte is presented on data_o |
| data_o | output | 8 | Data byte received while addressed |

## Verification
Two pairs of events can coincide, and both are tested on purpose. In the first, a register write lands in the same cycle as the address byte strobe. The bench expects the acknowledge to follow the old address, and then shows that only the new address matches after the next START. In the second, a STOP pulse is driven in the same cycle as a data byte strobe. The bench expects no acknowledge, no data strobe and a cleared selection one cycle later.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } am_state_e;

    typedef struct packed {
        am_state_e   st;
        logic        ack;
        logic        rw;
        logic        dstb;
        logic [7:0]  data;
    } am_seq_t;
endpackage

// File: rtl/i2cam_addr_reg.sv
module i2cam_addr_reg #(
    parameter int HI_W = 5,
    parameter logic [HI_W-1:0] RST_VAL = '0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic [HI_W-1:0] wdata_i,
    output logic [HI_W-1:0] hi_o
);
    logic [HI_W-1:0] hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (wr_i) hi_d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_q <= RST_VAL;
        else         hi_q <= hi_d;
    end

    assign hi_o = hi_q;
endmodule

// File: rtl/i2cam_strap_cap.sv
module i2cam_strap_cap #(
    parameter int LO_W = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [LO_W-1:0] strap_i,
    output logic [LO_W-1:0] lo_o
);
    logic [LO_W-1:0] lo_d, lo_q;

    // capture follows the pins only while reset is held
    always_comb begin
        lo_d = lo_q;
        if (!rst_ni) lo_d = strap_i;
    end

    always_ff @(posedge clk_i) begin
        lo_q <= lo_d;
    end

    assign lo_o = lo_q;
endmodule

// File: rtl/i2cam_cmp.sv
module i2cam_cmp #(
    parameter int ADDR_W = 7,
    parameter int HI_W   = 5,
    localparam int LO_W  = ADDR_W - HI_W,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [HI_W-1:0]   hi_i,
    input  logic [LO_W-1:0]   lo_i,
    output logic              hit_o
);
    logic own_hit, gc_hit;

    always_comb begin
        own_hit = (byte_i[BYTE_W-1:1] == {hi_i, lo_i});
        gc_hit  = (byte_i == '0);
        hit_o   = own_hit | gc_hit;
    end
endmodule

// File: rtl/i2cam_seq.sv
module i2cam_seq
    import i2cam_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              bv_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              hit_i,
    output logic              ack_o,
    output logic              addressed_o,
    output logic              rw_o,
    output logic              dstb_o,
    output logic [BYTE_W-1:0] data_o
);
    am_seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        s_d.dstb = 1'b0;
        if (!mode_i) begin
            s_d.st = ST_IDLE;
        end else if (stop_i) begin
            s_d.st = ST_IDLE;
        end else if (start_i) begin
            s_d.st = ST_ADDR;
        end else if (bv_i) begin
            unique case (s_q.st)
                ST_ADDR: begin
                    if (hit_i) begin
                        s_d.st  = ST_DATA;
                        s_d.ack = 1'b1;
                        s_d.rw  = byte_i[0];
                    end else begin
                        s_d.st  = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    s_d.ack  = 1'b1;
                    s_d.dstb = 1'b1;
                    s_d.data = byte_i;
                end
                default: s_d.st = s_q.st;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st   <= ST_IDLE;
            s_q.ack  <= 1'b0;
            s_q.rw   <= 1'b0;
            s_q.dstb <= 1'b0;
            s_q.data <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_o       = s_q.ack;
    assign addressed_o = (s_q.st == ST_DATA);
    assign rw_o        = s_q.rw;
    assign dstb_o      = s_q.dstb;
    assign data_o      = s_q.data;

    // R2
    ack_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> $past(bv_i));

    // R10
    mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i |=> (!ack_o && !addressed_o));

    // R8
    stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!addressed_o && !dstb_o));

    // R4
    rw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addressed_o && !start_i) |=> $stable(rw_o));

    // R6
    dstb_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dstb_o |-> (ack_o && addressed_o));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 7,
    parameter int HI_W   = 5,
    parameter logic [HI_W-1:0] HI_RST = '0,
    localparam int LO_W   = ADDR_W - HI_W,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              slave_mode_i,
    input  logic              addr_wr_i,
    input  logic [HI_W-1:0]   addr_wdata_i,
    input  logic [LO_W-1:0]   strap_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              ack_o,
    output logic              addressed_o,
    output logic              rw_o,
    output logic              data_stb_o,
    output logic [BYTE_W-1:0] data_o
);
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic            hit;

    i2cam_addr_reg #(.HI_W(HI_W), .RST_VAL(HI_RST)) u_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(addr_wr_i),
        .wdata_i(addr_wdata_i), .hi_o(hi)
    );

    i2cam_strap_cap #(.LO_W(LO_W)) u_strap (
        .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .lo_o(lo)
    );

    i2cam_cmp #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_cmp (
        .byte_i(byte_i), .hi_i(hi), .lo_i(lo), .hit_o(hit)
    );

    i2cam_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(slave_mode_i),
        .start_i(start_i), .stop_i(stop_i), .bv_i(byte_valid_i),
        .byte_i(byte_i), .hit_i(hit), .ack_o(ack_o),
        .addressed_o(addressed_o), .rw_o(rw_o), .dstb_o(data_stb_o),
        .data_o(data_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!ack_o && !addressed_o && !data_stb_o));
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b1;
    logic       wr = 1'b0;
    logic [4:0] wdata = '0;
    logic [1:0] strap = 2'b10;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       bv = 1'b0;
    logic [7:0] bdata = '0;
    logic       ack, addressed, rw, dstb;
    logic [7:0] dout;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match i_i2c_addr_match (
        .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(mode),
        .addr_wr_i(wr), .addr_wdata_i(wdata), .strap_i(strap),
        .start_i(start), .stop_i(stop), .byte_valid_i(bv), .byte_i(bdata),
        .ack_o(ack), .addressed_o(addressed), .rw_o(rw),
        .data_stb_o(dstb), .data_o(dout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); bv = 1'b1; bdata = b;
        @(negedge clk); bv = 1'b0;
    endtask

    task automatic write_reg(input logic [4:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ack", ack, 0);
        chk("R1 addressed", addressed, 0);
        chk("R1 dstb", dstb, 0);
        chk("R1 rw", rw, 0);
    endtask

    // own address = {10100, 10} = 7'h52 -> bytes A4 (write) / A5 (read)
    task automatic t_own_write();
        do_start();
        send(8'hA4);
        chk("R2 ack", ack, 1);
        chk("R2 addressed", addressed, 1);
        chk("R4 rw write", rw, 0);
        send(8'h3C);
        chk("R6 ack data", ack, 1);
        chk("R6 dstb", dstb, 1);
        chk("R6 data", dout, 8'h3C);
        send(8'hA4);
        chk("R7 address-like data", dstb, 1);
        chk("R7 data value", dout, 8'hA4);
        do_stop();
        chk("R8 addressed cleared", addressed, 0);
        send(8'hA4);
        chk("R8 no ack after stop", ack, 0);
    endtask

    task automatic t_own_read();
        do_start();
        send(8'hA5);
        chk("R4 ack read", ack, 1);
        chk("R4 rw read", rw, 1);
        do_stop();
    endtask

    task automatic t_mismatch();
        do_start();
        send(8'hA6);
        chk("R5 mismatch no ack", ack, 0);
        chk("R5 not addressed", addressed, 0);
        send(8'hA4);
        chk("R5 later byte no ack", ack, 0);
        do_start();
        send(8'hA4);
        chk("R5 next start matches", ack, 1);
        do_stop();
    endtask

    task automatic t_gcall();
        do_start();
        send(8'hA5);
        do_stop();
        do_start();
        send(8'h00);
        chk("R3 gc ack", ack, 1);
        chk("R3 gc addressed", addressed, 1);
        chk("R3 gc rw", rw, 0);
        send(8'h77);
        chk("R6 gc data dstb", dstb, 1);
        chk("R6 gc data", dout, 8'h77);
        do_stop();
        do_start();
        send(8'h01);
        chk("R3 addr0 read not gc", ack, 0);
        do_stop();
    endtask

    task automatic t_rstart();
        do_start();
        send(8'hA4);
        chk("R9 first rw", rw, 0);
        do_start();
        send(8'hA5);
        chk("R9 restart ack", ack, 1);
        chk("R9 restart rw", rw, 1);
        chk("R9 restart dstb", dstb, 0);
        do_stop();
    endtask

    task automatic t_mode();
        do_start();
        send(8'hA4);
        @(negedge clk); mode = 1'b0;
        @(negedge clk);
        chk("R10 addressed dropped", addressed, 0);
        do_start();
        send(8'hA4);
        chk("R10 no ack when off", ack, 0);
        mode = 1'b1;
    endtask

    task automatic t_regwr_same();
        do_start();
        @(negedge clk); bv = 1'b1; bdata = 8'hA4; wr = 1'b1; wdata = 5'b00011;
        @(negedge clk); bv = 1'b0; wr = 1'b0;
        chk("R11 old value used", ack, 1);
        do_stop();
        do_start();
        send(8'hA4);
        chk("R11 old address rejected", ack, 0);
        do_start();
        send(8'h1C);
        chk("R11 new address matches", ack, 1);
        do_stop();
        write_reg(5'b10100);
    endtask

    task automatic t_strap();
        @(negedge clk); strap = 2'b01;
        do_start();
        send(8'hA4);
        chk("R12 straps held", ack, 1);
        do_stop();
        do_start();
        send(8'hA2);
        chk("R12 new pins ignored", ack, 0);
        do_stop();
    endtask

    task automatic t_stop_byte();
        do_start();
        send(8'hA4);
        @(negedge clk); stop = 1'b1; bv = 1'b1; bdata = 8'h5A;
        @(negedge clk); stop = 1'b0; bv = 1'b0;
        chk("R13 no ack", ack, 0);
        chk("R13 no dstb", dstb, 0);
        chk("R13 addressed cleared", addressed, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        write_reg(5'b10100);
        t_own_write();
        t_own_read();
        t_mismatch();
        t_gcall();
        t_rstart();
        t_mode();
        t_regwr_same();
        t_strap();
        t_stop_byte();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule